// File: doc/BRIEF.md
# Internal Oscillator Rate Postscaler

This block produces the system clock tick from a fast internal reference. The reference clock `clk` runs at the nominal 8 MHz. A power-of-two postscaler turns it into one of eight output rates, chosen by a 3-bit rate code. Each rate leaves the block as a one-cycle enable pulse `sys_tick` in the reference domain, so downstream logic keeps running on `clk` and advances only when the pulse is high.

The codes from 1 to 7 form a halving ladder that starts at the full reference rate. Code 0 does not continue that ladder. It selects a nominal 31 kHz rate, and a tune input decides where that rate comes from: either the reference divided by 256, or an independent slow RC oscillator. The slow RC oscillator reaches the block as a one-cycle enable input. A second tune input asks for a 4x multiplied fast clock. It is honoured only at the top code, and the block reports whether it is active. The slow RC pulse is also passed on, one cycle later, to always-on consumers such as a watchdog, whatever rate is selected.

Rate changes are glitch-free. A new request is loaded only at the boundary of the period that is running, and a completion flag reports when the first pulse at the new rate has been issued.

Top module: `osc_postscaler`

## Requirements
- R1: While `rst` is high, `sys_tick`, `switch_done`, `mult_active` and `wdt_tick` are 0 and the running rate code is 6. When `rst` is released with code 6 requested, the first `sys_tick` comes on the second rising edge, and `switch_done` is 1 from that pulse.
- R2: With rate code c from 1 to 7 running, `sys_tick` pulses every 2^(7-c) cycles. Code 7 pulses on every cycle and code 1 every 64 cycles.
- R3: With code 0 running and `slow_from_ref` = 1, `sys_tick` pulses every 256 cycles.
- R4: With code 0 running and `slow_from_ref` = 0, `sys_tick` pulses one cycle after each `slow_rc_tick` pulse, so its spacing equals the spacing of `slow_rc_tick`.
- R5: When code 7 is running with `mult_en` = 1, `mult_active` is 1 and `sys_tick` is high on every cycle. With any other code, `mult_en` has no effect on the period, `mult_active` or `switch_done`.
- R6: `slow_from_ref` has no effect on the period or on `switch_done` unless the code is 0.
- R7: A request change loads only at the next pulse boundary of the running rate. The period in progress finishes at its old length whenever the change arrives, and no extra or shortened pulse is emitted.
- R8: `switch_done` falls together with the pulse that ends the last old period, if the effective request differs from the running rate. It rises together with the first pulse of the new rate. It changes only together with a `sys_tick` pulse.
- R9: `wdt_tick` equals `slow_rc_tick` delayed by one cycle, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast internal reference clock (nominal 8 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 3 | Requested rate code (7 = full rate, 0 = nominal 31 kHz) |
| slow_from_ref | input | 1 | Code 0 source: 1 = reference divided by 256, 0 = slow RC |
| mult_en | input | 1 | Request the 4x multiplied fast clock (code 7 only) |
| slow_rc_tick | input | 1 | One-cycle enable pulse from the slow RC oscillator |
| sys_tick | output | 1 | One-cycle enable pulse at the running rate |
| mult_active | output | 1 | The 4x multiplied fast clock is the running choice |
| switch_done | output | 1 | The first pulse at the running rate has been issued |
| wdt_tick | output | 1 | Slow RC pulse passed on for always-on consumers |

## Verification
The assertions assume that `slow_rc_tick` is a pulse synchronous to `clk` and that the request inputs are stable around each rising edge. They also assume that reset is held for at least one edge before any property is checked. The stimulus drives the slow RC pulse for exactly one cycle out of every 40. It changes requests only between edges, either right after an observed `sys_tick` or partway through a long period, and it holds each request for several full periods.

// File: rtl/osc_ps_pkg.sv
package osc_ps_pkg;

    localparam int SEL_W    = 3;
    localparam int TOP_CODE = (1 << SEL_W) - 1;

    // Effective rate request after irrelevant tune bits are masked.
    typedef struct packed {
        logic [SEL_W-1:0] code;
        logic             from_ref;
        logic             mult;
    } rate_cfg_t;

    function automatic rate_cfg_t norm_cfg(logic [SEL_W-1:0] code,
                                           logic fr, logic me);
        rate_cfg_t r;
        r.code     = code;
        r.from_ref = fr & (code == '0);
        r.mult     = me & (code == SEL_W'(TOP_CODE));
        return r;
    endfunction

    function automatic logic uses_slow_rc(rate_cfg_t c);
        return (c.code == '0) && !c.from_ref;
    endfunction

    // log2 of the divide ratio of the running rate
    function automatic int unsigned div_log2(rate_cfg_t c, int unsigned slow_log2);
        if (c.code == '0)
            return slow_log2;
        return int'(TOP_CODE) - int'(c.code);
    endfunction

endpackage

// File: rtl/osc_div_counter.sv
module osc_div_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] last,
    input  logic             use_ext,
    input  logic             ext_tick,
    output logic             hit,
    output logic [CNT_W-1:0] cnt
);

    always_comb begin
        hit = use_ext ? ext_tick : (cnt == last);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (hit || use_ext)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/osc_rate_switch.sv
module osc_rate_switch
    import osc_ps_pkg::*;
#(
    parameter int RST_CODE = 6
) (
    input  logic      clk,
    input  logic      rst,
    input  rate_cfg_t req,
    input  logic      hit,
    output rate_cfg_t run,
    output logic      done,
    output logic      tick
);

    always_ff @(posedge clk) begin
        if (rst) begin
            run.code     <= SEL_W'(RST_CODE);
            run.from_ref <= 1'b0;
            run.mult     <= 1'b0;
            done         <= 1'b0;
            tick         <= 1'b0;
        end else begin
            tick <= hit;
            if (hit) begin
                if (req != run) begin
                    run  <= req;
                    done <= 1'b0;
                end else begin
                    done <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/osc_postscaler.sv
module osc_postscaler
    import osc_ps_pkg::*;
#(
    parameter int SLOW_LOG2 = 8,
    parameter int RST_CODE  = 6,
    localparam int LADDER_W = TOP_CODE - 1,
    localparam int CNT_W    = (SLOW_LOG2 > LADDER_W) ? SLOW_LOG2 : LADDER_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] rate_sel,
    input  logic             slow_from_ref,
    input  logic             mult_en,
    input  logic             slow_rc_tick,
    output logic             sys_tick,
    output logic             mult_active,
    output logic             switch_done,
    output logic             wdt_tick
);

    rate_cfg_t        req_cfg;
    rate_cfg_t        run_cfg;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] div_last;
    logic [CNT_W-1:0] div_cnt;
    logic             use_rc;
    logic             div_hit;

    always_comb begin
        req_cfg  = norm_cfg(rate_sel, slow_from_ref, mult_en);
        use_rc   = uses_slow_rc(run_cfg);
        span     = (CNT_W+1)'(1) << div_log2(run_cfg, SLOW_LOG2);
        div_last = CNT_W'(span - 1'b1);
    end

    osc_div_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .last     (div_last),
        .use_ext  (use_rc),
        .ext_tick (slow_rc_tick),
        .hit      (div_hit),
        .cnt      (div_cnt)
    );

    osc_rate_switch #(.RST_CODE(RST_CODE)) u_sw (
        .clk  (clk),
        .rst  (rst),
        .req  (req_cfg),
        .hit  (div_hit),
        .run  (run_cfg),
        .done (switch_done),
        .tick (sys_tick)
    );

    assign mult_active = run_cfg.mult;

    always_ff @(posedge clk) begin
        if (rst)
            wdt_tick <= 1'b0;
        else
            wdt_tick <= slow_rc_tick;
    end

endmodule

// File: rtl/osc_postscaler_chk.sv
module osc_postscaler_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             sys_tick,
    input logic             switch_done,
    input logic             mult_active,
    input logic             wdt_tick,
    input logic             slow_rc_tick,
    input logic [CNT_W-1:0] div_cnt,
    input logic [CNT_W-1:0] div_last
);

    AST_CNT_WITHIN_PERIOD: assert property (@(posedge clk) disable iff (rst)
        div_cnt <= div_last); // R7

    AST_MULT_FULL_RATE: assert property (@(posedge clk) disable iff (rst)
        mult_active |-> sys_tick); // R5

    AST_DONE_RISE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(switch_done) |-> sys_tick); // R8

    AST_DONE_FALL_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $fell(switch_done) |-> sys_tick); // R7

    AST_MULT_RISE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(mult_active) |-> sys_tick); // R5

    AST_WDT_FOLLOWS_RC: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (wdt_tick == $past(slow_rc_tick))); // R9

endmodule

bind osc_postscaler osc_postscaler_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .sys_tick     (sys_tick),
    .switch_done  (switch_done),
    .mult_active  (mult_active),
    .wdt_tick     (wdt_tick),
    .slow_rc_tick (slow_rc_tick),
    .div_cnt      (div_cnt),
    .div_last     (div_last)
);

// File: tb/osc_postscaler_tb_top.sv
module osc_postscaler_tb_top;
    import osc_ps_pkg::*;

    localparam int RC_GAP = 40;

    typedef struct {
        int    per;
        string tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [SEL_W-1:0] rate_sel = 3'd6;
    logic             slow_from_ref = 1'b0;
    logic             mult_en = 1'b0;
    logic             slow_rc_tick = 1'b0;
    logic             sys_tick, mult_active, switch_done, wdt_tick;

    int   n_vec = 0;
    int   n_bad = 0;
    exp_t exp_q[$];
    exp_t cur_e;
    event pulse_ev;
    int   since = 0;
    logic prev_slow = 1'b0;
    bit   run_mon = 1'b0;
    int   cur_code = 6;
    bit   cur_fr = 1'b0;
    bit   cur_me = 1'b0;
    int   prev_per = 2;

    always #5 clk = ~clk;

    osc_postscaler dut_i (
        .clk           (clk),
        .rst           (rst),
        .rate_sel      (rate_sel),
        .slow_from_ref (slow_from_ref),
        .mult_en       (mult_en),
        .slow_rc_tick  (slow_rc_tick),
        .sys_tick      (sys_tick),
        .mult_active   (mult_active),
        .switch_done   (switch_done),
        .wdt_tick      (wdt_tick)
    );

    function automatic void chk(bit ok, string tag, int act, int expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endfunction

    function automatic int period_of(int code, bit fr);
        if (code == 7) return 1;
        if (code != 0) return 1 << (7 - code);
        return fr ? 256 : RC_GAP;
    endfunction

    // slow RC source: one-cycle pulse every RC_GAP cycles
    initial begin
        forever begin
            repeat (RC_GAP - 1) @(posedge clk);
            #1 slow_rc_tick = 1'b1;
            @(posedge clk);
            #1 slow_rc_tick = 1'b0;
        end
    end

    // monitor: measures pulse spacing and pops the scoreboard
    always @(negedge clk) begin
        if (run_mon) begin
            since++;
            chk(wdt_tick === prev_slow, "R9", int'(wdt_tick), int'(prev_slow));
            prev_slow = slow_rc_tick;
            if (sys_tick === 1'b1) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected pulse", since, 0);
                end else begin
                    cur_e = exp_q.pop_front();
                    if (cur_e.per != 0)
                        chk(since == cur_e.per, cur_e.tag, since, cur_e.per);
                end
                since = 0;
                ->pulse_ev;
            end
        end
    end

    // driver: called right after a pulse; queues the expected spacings
    task automatic step(int code, bit fr, bit me, int n, int dly, string tag);
        bit nf = fr && (code == 0);
        bit nm = me && (code == 7);
        bit changed = (code != cur_code) || (nf != cur_fr) || (nm != cur_me);
        int np = period_of(code, nf);
        bit rc = (code == 0) && !nf;
        if (dly > 0) repeat (dly) @(negedge clk);
        rate_sel      = SEL_W'(code);
        slow_from_ref = fr;
        mult_en       = me;
        exp_q.push_back('{prev_per, "R7"});
        if (rc) begin
            exp_q.push_back('{0, tag});
            for (int i = 0; i < n - 2; i++) exp_q.push_back('{np, tag});
        end else begin
            for (int i = 0; i < n - 1; i++) exp_q.push_back('{np, tag});
        end
        @(pulse_ev);
        chk(switch_done === !changed, "R8", int'(switch_done), int'(!changed));
        repeat (n - 1) @(pulse_ev);
        chk(switch_done === 1'b1, "R8", int'(switch_done), 1);
        chk(mult_active === nm, "R5", int'(mult_active), int'(nm));
        cur_code = code;
        cur_fr   = nf;
        cur_me   = nm;
        prev_per = np;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        #1;
        chk(sys_tick === 1'b0, "R1", int'(sys_tick), 0);
        chk(switch_done === 1'b0, "R1", int'(switch_done), 0);
        chk(mult_active === 1'b0, "R1", int'(mult_active), 0);
        chk(wdt_tick === 1'b0, "R1", int'(wdt_tick), 0);
        exp_q.push_back('{2, "R1"});
        prev_slow = slow_rc_tick;
        since     = 0;
        rst       = 1'b0;
        run_mon   = 1'b1;
        @(pulse_ev);
        chk(switch_done === 1'b1, "R1", int'(switch_done), 1);

        step(7, 0, 0, 4, 0,  "R2");
        step(7, 0, 1, 4, 0,  "R5");
        step(6, 0, 1, 4, 0,  "R5");
        step(6, 0, 0, 3, 0,  "R5");
        step(1, 0, 0, 3, 0,  "R2");
        step(4, 0, 0, 3, 10, "R7");
        step(0, 1, 0, 3, 0,  "R3");
        step(0, 0, 0, 4, 0,  "R4");
        step(2, 1, 0, 3, 0,  "R6");
        step(2, 0, 0, 3, 0,  "R6");
        step(3, 0, 0, 3, 0,  "R2");
        step(5, 0, 0, 3, 0,  "R2");
        step(0, 1, 1, 3, 0,  "R3");
        step(7, 1, 1, 4, 0,  "R5");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule